// File: doc/BRIEF.md
# Multiplexed-Address 4096x1 Dynamic RAM Model

This block is a synthesizable, cycle-level stand-in for a 4096-word by 1-bit dynamic RAM that takes its 12-bit cell address in two halves over six pins. It is meant to sit on a fast system clock next to a memory controller under test. The controller drives it through the usual active-low row strobe, column strobe and write strobe, an active-low chip select, the six address pins and one data-in pin. The model answers with a registered data-out bit and an output-enable that stands for the three-state output buffer.

All pin inputs pass through a multi-flop synchroniser together, so they stay aligned with one another. Strobe falling edges are then found by comparing each synchronised strobe with its value one clock earlier. The row half is taken when the row strobe falls. The column half and the select state are taken when the column strobe falls. The model then applies the output-latch rules of the device: the output goes open on every column strobe fall, and it reappears after the access delay with either the stored bit or a forced one. It then holds through refresh-only cycles. Cell decay and analog timing are not modelled. Access time is a pair of parameters in system clocks.

Top module: `dram_emu_top`

## Requirements
- R1: The cell address is {row, column}: the row is the address pins at the synchronised row-strobe fall and forms the upper 6 bits, and the column is the address pins at the column-strobe fall and forms the lower 6 bits. Different (row, column) pairs reach different cells, including a pair and its swap.
- R2: One clock after every synchronised column-strobe fall, dout_en is 0, whatever the other inputs are.
- R3: In a selected cycle where the write strobe is high at the column-strobe fall, dout shows the stored bit of the addressed cell, not inverted, once dout_en rises.
- R4: In a selected cycle where the write strobe is already low at the column-strobe fall (early write), din is stored in the cell, and dout shows 1 once dout_en rises.
- R5: Once dout_en is 1, dout_en and dout keep their values until the next column-strobe fall. A refresh-only cycle (row strobe only) changes neither.
- R6: If cs_n is high at the column-strobe fall, no cell is written in that cycle and dout_en stays 0 for that cycle.
- R7: After reset dout_en is 0. The first cycle that uses both the row and the column strobe drives no output. Only later selected cycles can set dout_en.
- R8: dout_en rises on the first clock at which at least CAS_ACC clocks have passed since the synchronised column-strobe fall and at least RAS_ACC clocks have passed since the synchronised row-strobe fall. An early column strobe therefore waits for the row-based limit.
- R9: In a selected cycle that is not an early write, a fall of the write strobe while the column strobe is low stores din into the latched cell (delayed write or read-modify-write).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| cs_n | input | 1 | Chip select, active low, sampled at column-strobe fall |
| addr | input | 6 | Multiplexed row/column address |
| din | input | 1 | Write data |
| dout | output | 1 | Registered read data |
| dout_en | output | 1 | High while the modelled output buffer drives dout |

## Verification
The checker watches, on every clock, that the output goes open after each column-strobe fall. It also checks that a driven output stays steady until the next one, that nothing is written when the chip is unselected, that no output appears before the initialising cycle, and that dout_en never rises before both access windows have elapsed. Only the bench scenarios can show the data itself. They cover stored bits read back unchanged, the forced one after an early write, the effect of a delayed write, separate cells for a row/column swap, and the exact extra latency when the column strobe comes early. A behavioural model in the bench follows every clock.

// File: rtl/dram_emu_pkg.sv
package dram_emu_pkg;
  parameter int unsigned HALF_W = 6;
  parameter int unsigned CELL_W = 2 * HALF_W;

  typedef struct packed {
    logic              ras_n;
    logic              cas_n;
    logic              we_n;
    logic              sel_n;
    logic              din;
    logic [HALF_W-1:0] addr;
  } pins_t;

  localparam int unsigned PINS_W = $bits(pins_t);

  localparam pins_t PINS_IDLE = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1,
                                  sel_n: 1'b1, din: 1'b0, addr: '0};
endpackage

// File: rtl/dram_emu_sync.sv
module dram_emu_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage[i] <= RST_VAL;
        else     stage[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage[i] <= RST_VAL;
        else     stage[i] <= stage[i-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/dram_emu_edge.sv
module dram_emu_edge #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cur,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= RST_VAL;
    else     prev <= cur;
  end

  assign fall = prev & ~cur;
endmodule

// File: rtl/dram_emu_array.sv
module dram_emu_array #(
  parameter int unsigned AW = 12
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_data
);
  localparam int unsigned DEPTH = 1 << AW;

  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/dram_emu_top.sv
module dram_emu_top
  import dram_emu_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CAS_ACC     = 4,
  parameter int unsigned RAS_ACC     = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              cs_n,
  input  logic [HALF_W-1:0] addr,
  input  logic              din,
  output logic              dout,
  output logic              dout_en
);
  localparam int unsigned CW = $clog2(CAS_ACC + 1);
  localparam int unsigned RW = $clog2(RAS_ACC + 1);
  localparam logic [CW-1:0] CAS_LIM = CW'(CAS_ACC);
  localparam logic [RW-1:0] RAS_LIM = RW'(RAS_ACC);

  // synchronised pin bundle
  pins_t raw_pins, s;
  assign raw_pins = '{ras_n: ras_n, cas_n: cas_n, we_n: we_n,
                      sel_n: cs_n, din: din, addr: addr};

  dram_emu_sync #(
    .W(PINS_W), .STAGES(SYNC_STAGES), .RST_VAL(PINS_IDLE)
  ) u_sync (
    .clk(clk), .rst(rst), .d(raw_pins), .q(s)
  );

  // strobe falling edges: [2]=row, [1]=column, [0]=write
  logic [2:0] strobe_fall;
  logic       ras_fall, cas_fall, we_fall;

  dram_emu_edge #(.W(3), .RST_VAL(3'b111)) u_edge (
    .clk(clk), .rst(rst),
    .cur({s.ras_n, s.cas_n, s.we_n}),
    .fall(strobe_fall)
  );
  assign ras_fall = strobe_fall[2];
  assign cas_fall = strobe_fall[1];
  assign we_fall  = strobe_fall[0];

  logic ras_low, cas_low;
  assign ras_low = ~s.ras_n;
  assign cas_low = ~s.cas_n;

  // cycle state
  logic [HALF_W-1:0] row_q, col_q;
  logic              sel_q, early_q, pending_q, init_q;
  logic [CW-1:0]     cas_cnt;
  logic [RW-1:0]     ras_cnt;

  // array port
  logic              wr_en, wr_data, rd_bit;
  logic [CELL_W-1:0] wr_addr, rd_addr;
  logic              early_wr, late_wr, fire;

  assign early_wr = cas_fall & ras_low & ~s.sel_n & ~s.we_n;
  assign late_wr  = we_fall & ~cas_fall & cas_low & sel_q & ~early_q;
  assign wr_en    = early_wr | late_wr;
  assign wr_addr  = cas_fall ? {row_q, s.addr} : {row_q, col_q};
  assign wr_data  = s.din;
  assign rd_addr  = {row_q, col_q};

  dram_emu_array #(.AW(CELL_W)) u_array (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_bit)
  );

  assign fire = pending_q && (cas_cnt >= CAS_LIM) && (ras_cnt >= RAS_LIM);

  // row side: address latch and row-based access window
  always_ff @(posedge clk) begin
    if (rst) begin
      row_q   <= '0;
      ras_cnt <= '0;
    end else if (ras_fall) begin
      row_q   <= s.addr;
      ras_cnt <= RW'(1);
    end else if (ras_cnt != '0 && ras_cnt < RAS_LIM) begin
      ras_cnt <= ras_cnt + RW'(1);
    end
  end

  // column side: select latch, output latch and column-based window
  always_ff @(posedge clk) begin
    if (rst) begin
      col_q     <= '0;
      sel_q     <= 1'b0;
      early_q   <= 1'b0;
      pending_q <= 1'b0;
      init_q    <= 1'b0;
      cas_cnt   <= '0;
      dout      <= 1'b0;
      dout_en   <= 1'b0;
    end else if (cas_fall) begin
      col_q     <= s.addr;
      sel_q     <= ras_low & ~s.sel_n;
      early_q   <= ~s.we_n;
      pending_q <= ras_low & ~s.sel_n & init_q;
      if (ras_low) init_q <= 1'b1;
      cas_cnt   <= CW'(1);
      dout_en   <= 1'b0;
    end else begin
      if (pending_q && cas_cnt < CAS_LIM) cas_cnt <= cas_cnt + CW'(1);
      if (fire) begin
        dout_en   <= 1'b1;
        dout      <= early_q ? 1'b1 : rd_bit;
        pending_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dram_emu_chk.sv
module dram_emu_chk #(
  parameter int unsigned CAS_ACC = 4,
  parameter int unsigned RAS_ACC = 7
) (
  input logic clk,
  input logic rst,
  input logic ras_fall,
  input logic cas_fall,
  input logic sel_n_s,
  input logic wr_en,
  input logic init_q,
  input logic dout_en,
  input logic dout
);
  localparam int unsigned CW = $clog2(CAS_ACC + 2);
  localparam int unsigned RW = $clog2(RAS_ACC + 2);

  logic [CW-1:0] since_cas;
  logic [RW-1:0] since_ras;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_cas <= '0;
      since_ras <= '0;
    end else begin
      if (cas_fall) since_cas <= CW'(1);
      else if (since_cas != '0 && since_cas < CW'(CAS_ACC + 1)) since_cas <= since_cas + CW'(1);
      if (ras_fall) since_ras <= RW'(1);
      else if (since_ras != '0 && since_ras < RW'(RAS_ACC + 1)) since_ras <= since_ras + RW'(1);
    end
  end

  a_r2_open_on_cas: assert property (@(posedge clk) disable iff (rst)
    cas_fall |=> !dout_en);

  a_r5_hold_value: assert property (@(posedge clk) disable iff (rst)
    (dout_en && !cas_fall) |=> (dout_en && $stable(dout)));

  a_r6_unsel_no_write: assert property (@(posedge clk) disable iff (rst)
    (cas_fall && sel_n_s) |-> !wr_en);

  a_r7_init_gate: assert property (@(posedge clk) disable iff (rst)
    !init_q |-> !dout_en);

  a_r8_min_access: assert property (@(posedge clk) disable iff (rst)
    $rose(dout_en) |-> ((since_cas > CW'(CAS_ACC)) && (since_ras > RW'(RAS_ACC))));
endmodule

bind dram_emu_top dram_emu_chk #(.CAS_ACC(CAS_ACC), .RAS_ACC(RAS_ACC)) u_chk (
  .clk(clk), .rst(rst), .ras_fall(ras_fall), .cas_fall(cas_fall),
  .sel_n_s(s.sel_n), .wr_en(wr_en), .init_q(init_q),
  .dout_en(dout_en), .dout(dout)
);

// File: tb/tb_dram_emu_top.sv
module tb_dram_emu_top;
  localparam int CA = 4;
  localparam int RA = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cs_n = 1'b1, din = 1'b0;
  logic [5:0] addr = '0;
  logic dout, dout_en;

  always #5 clk = ~clk;

  dram_emu_top #(.SYNC_STAGES(2), .CAS_ACC(CA), .RAS_ACC(RA)) dut (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cs_n(cs_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_int(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---- behavioural reference model: pins seen two clocks late ----
  typedef struct packed {
    logic ras, cas, we, sel, d;
    logic [5:0] a;
  } pin_s;
  localparam pin_s IDLE = '{ras: 1, cas: 1, we: 1, sel: 1, d: 0, a: 0};

  pin_s hq[$];
  bit   mm [4096];
  int   m_row, m_col, m_rc, m_cc;
  bit   m_sel, m_early, m_pend, m_init, m_oe, m_dout;

  always @(posedge clk) begin
    pin_s cur, sp, pp;
    bit rf, cf, wf, fire, rd;
    if (rst) begin
      hq = '{IDLE, IDLE, IDLE, IDLE};
      m_row = 0; m_col = 0; m_rc = 0; m_cc = 0;
      m_sel = 0; m_early = 0; m_pend = 0; m_init = 0; m_oe = 0; m_dout = 0;
    end else begin
      cur = '{ras: ras_n, cas: cas_n, we: we_n, sel: cs_n, d: din, a: addr};
      hq.push_front(cur);
      sp = hq[2];
      pp = hq[3];
      void'(hq.pop_back());
      rf = pp.ras && !sp.ras;
      cf = pp.cas && !sp.cas;
      wf = pp.we && !sp.we;
      fire = m_pend && m_cc >= CA && m_rc >= RA;
      rd = mm[m_row * 64 + m_col];
      if (cf && !sp.ras && !sp.sel && !sp.we) mm[m_row * 64 + sp.a] = sp.d;
      if (wf && !cf && !sp.cas && m_sel && !m_early) mm[m_row * 64 + m_col] = sp.d;
      if (rf) begin
        m_row = sp.a; m_rc = 1;
      end else if (m_rc != 0 && m_rc < RA) m_rc++;
      if (cf) begin
        m_col = sp.a;
        m_sel = !sp.ras && !sp.sel;
        m_early = !sp.we;
        m_pend = !sp.ras && !sp.sel && m_init;
        if (!sp.ras) m_init = 1;
        m_cc = 1;
        m_oe = 0;
      end else begin
        if (m_pend && m_cc < CA) m_cc++;
        if (fire) begin
          m_oe = 1; m_dout = m_early ? 1'b1 : rd; m_pend = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check("R8 model dout_en", dout_en, m_oe);
      if (m_oe) check("R3 model dout", dout, m_dout);
    end
  end

  // ---- watchdog ----
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog R8 actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // ---- stimulus ----
  int  last_lat;
  bit  saw_low;

  task automatic mcycle(int row, int col, bit sel, bit early, bit d,
                        bit dly, bit dd, int r2c);
    @(negedge clk);
    addr = 6'(row); ras_n = 0;
    repeat (r2c) @(negedge clk);
    addr = 6'(col); cs_n = !sel; we_n = !early; din = d; cas_n = 0;
    last_lat = -1; saw_low = 0;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      if (!dout_en) saw_low = 1;
      else if (saw_low && last_lat < 0) last_lat = i;
    end
    if (dly) begin
      din = dd; we_n = 0;
      repeat (3) @(negedge clk);
    end
    cas_n = 1; ras_n = 1; we_n = 1; cs_n = 1;
    repeat (5) @(negedge clk);
  endtask

  task automatic refresh_only(int row);
    @(negedge clk);
    addr = 6'(row); ras_n = 0;
    repeat (8) @(negedge clk);
    ras_n = 1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R7 reset dout_en", dout_en, 1'b0);
    rst = 0;
    repeat (3) @(negedge clk);

    // initialising cycle: no output
    mcycle(0, 0, 1, 0, 0, 0, 0, 4);
    check("R7 first cycle open", dout_en, 1'b0);

    // early write of 0 at (5,9): output forced 1
    mcycle(5, 9, 1, 1, 0, 0, 0, 4);
    check("R4 early write enable", dout_en, 1'b1);
    check("R4 early write shows 1", dout, 1'b1);
    check_int("R8 latency normal", last_lat, 7);

    // read back (5,9)
    mcycle(5, 9, 1, 0, 0, 0, 0, 4);
    check("R2 open seen", saw_low, 1'b1);
    check("R3 read stored 0", dout, 1'b0);

    // swapped pair holds a different bit
    mcycle(9, 5, 1, 1, 1, 0, 0, 4);
    mcycle(9, 5, 1, 0, 0, 0, 0, 4);
    check("R1 read (9,5)", dout, 1'b1);
    mcycle(5, 9, 1, 0, 0, 0, 0, 4);
    check("R1 read (5,9) untouched", dout, 1'b0);

    // refresh-only keeps the latch
    refresh_only(12);
    check("R5 hold enable", dout_en, 1'b1);
    check("R5 hold value", dout, 1'b0);

    // unselected early write of 1 at (5,9)
    mcycle(5, 9, 0, 1, 1, 0, 0, 4);
    check("R6 unselected open", dout_en, 1'b0);
    check("R2 driven output dropped", saw_low, 1'b1);
    mcycle(5, 9, 1, 0, 0, 0, 0, 4);
    check("R6 cell unchanged", dout, 1'b0);

    // read-modify-write on (9,5): read 1, write 0
    mcycle(9, 5, 1, 0, 0, 1, 0, 4);
    check("R3 rmw read part", dout, 1'b1);
    mcycle(9, 5, 1, 0, 0, 0, 0, 4);
    check("R9 delayed write stored", dout, 1'b0);

    // early column strobe: row window governs
    mcycle(9, 5, 1, 0, 0, 0, 0, 1);
    check_int("R8 latency early column", last_lat, 9);
    check("R8 early column data", dout, 1'b0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule